// File: doc/BRIEF.md
# Half-Integer Clock Divider Branch

This block builds one derived clock out of several candidate source clocks. The chosen source passes through a selector that switches without glitches, then through an enable gate, and then through a divider. The divider ratio is N + 1.5 for a programmable field value N, so the available ratios are 1.5, 2.5, 3.5 and upward. The output period spans an odd number of source half-periods. For that reason the divider advances on both source edges, and each output period begins alternately on a rising and on a falling source edge. The output duty cycle stays as close to 50% as an odd half-period count allows.

Configuration arrives as 32-bit word writes to two targets: a control word that holds the selector and divider fields, and a gate word that holds the enable bit. A build-time option turns the upper halfword of every written word into a per-bit write-enable mask, so that software can change one field without first reading the word back. Another build-time option freezes the selector, which makes selector writes ineffective.

In this model the source clocks are level signals. The block samples them on a fast system clock, and all of its state lives in that one clock domain.

Top module: `halfdiv_clk_branch`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `clk_out` is low. Reset leaves the divider field at 0, the selector at source 0 and the gate disabled.
- R2: With divider field N, each output period lasts 2N+3 half-periods of the selected source. `clk_out` is high for the first N+2 of them and low for the remaining N+1.
- R3: N = 0 gives the smallest ratio, 1.5. An all-ones field (15 at the default width of 4) gives the largest ratio, 16.5.
- R4: A new divider value is applied only when the current output period ends, so no output period is shortened.
- R5: While the effective gate is off, `clk_out` is low. A change of the gate bit becomes effective only in a cycle where the selected source is sampled low.
- R6: A selector change becomes effective only when both the current source and the requested source are sampled low, so the selection itself adds no extra edge.
- R7: In masked mode (MASKED=1), bit k+16 of a written word enables the update of bit k, and every bit whose enable is 0 keeps its value. Field positions are: selector at bits [1:0] and divider at bits [11:8] of the control word (`wr_tgt`=0), and gate at bit 3 of the gate word (`wr_tgt`=1).
- R8: In plain mode (MASKED=0), a control-word write replaces the divider field and a writable selector field, and a gate-word write replaces the gate bit. Bits 31:16 of the word have no effect.
- R9: With a read-only selector (SEL_RO=1), writes leave the selection at source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sources and the write port |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | NSRC | Candidate source clocks, as level signals |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_tgt | input | 1 | Write target: 0 selects the control word, 1 selects the gate word |
| wr_data | input | 32 | Written word, with the optional mask in bits 31:16 |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The assertions assume that every source level lasts at least one system-clock cycle, so that no source edge falls between two samples. They also assume that selector values name an existing source and that the fields lie inside the lower halfword. The bench keeps within these limits: its sources toggle every 2, 3, 5 and 4 system cycles, and it writes selector values below four. One shared write stream drives a masked instance and a plain instance that has a read-only selector. The same words therefore reach both instances, and each interprets them under its own mode rules.

// File: rtl/halfdiv_pkg.sv
package halfdiv_pkg;

    localparam int WORD_W   = 32;
    localparam int MASK_OFS = 16;

    typedef enum logic {
        TGT_CTRL = 1'b0,
        TGT_GATE = 1'b1
    } wr_tgt_e;

    typedef struct packed {
        logic              en;
        wr_tgt_e           tgt;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    // counter must reach 2*(2^dw - 1) + 2
    function automatic int cnt_width(input int dw);
        return dw + 2;
    endfunction

    function automatic logic bit_we(input logic [WORD_W-1:0] d, input int pos, input bit masked);
        return masked ? d[MASK_OFS + pos] : 1'b1;
    endfunction

    function automatic logic merge_bit(input logic old_v, input logic new_v, input logic we);
        return we ? new_v : old_v;
    endfunction

endpackage

// File: rtl/halfdiv_regs.sv
module halfdiv_regs
    import halfdiv_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int SEL_LSB  = 0,
    parameter int DIV_W    = 4,
    parameter int DIV_LSB  = 8,
    parameter int GATE_BIT = 3,
    parameter bit MASKED   = 1'b1,
    parameter bit SEL_RO   = 1'b0,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    output logic [SEL_W-1:0] sel_req,
    output logic [DIV_W-1:0] div_req,
    output logic             gate_req
);

    logic wr_ctrl, wr_gate;
    logic [DIV_W-1:0] div_nx;
    logic unused_bits;

    assign wr_ctrl     = req.en && (req.tgt == TGT_CTRL);
    assign wr_gate     = req.en && (req.tgt == TGT_GATE);
    assign unused_bits = ^req.data;

    always_comb begin
        for (int i = 0; i < DIV_W; i++)
            div_nx[i] = merge_bit(div_req[i], req.data[DIV_LSB+i], bit_we(req.data, DIV_LSB+i, MASKED));
    end

    always_ff @(posedge clk) begin
        if (rst)          div_req <= '0;
        else if (wr_ctrl) div_req <= div_nx;
    end

    generate
        if (SEL_RO) begin : g_sel_fixed
            assign sel_req = '0;
        end else begin : g_sel_rw
            logic [SEL_W-1:0] sel_nx;
            always_comb begin
                for (int i = 0; i < SEL_W; i++)
                    sel_nx[i] = merge_bit(sel_req[i], req.data[SEL_LSB+i], bit_we(req.data, SEL_LSB+i, MASKED));
            end
            always_ff @(posedge clk) begin
                if (rst)          sel_req <= '0;
                else if (wr_ctrl) sel_req <= sel_nx;
            end
        end

        if (HAS_GATE) begin : g_gate_reg
            always_ff @(posedge clk) begin
                if (rst)          gate_req <= 1'b0;
                else if (wr_gate) gate_req <= merge_bit(gate_req, req.data[GATE_BIT], bit_we(req.data, GATE_BIT, MASKED));
            end
        end else begin : g_gate_none
            assign gate_req = 1'b1;
        end

        if (MASKED) begin : g_chk_masked
            assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (wr_ctrl && req.data[MASK_OFS+DIV_LSB +: DIV_W] == '0) |=> $stable(div_req));
        end else begin : g_chk_plain
            assert_plain_replace_R8: assert property (@(posedge clk) disable iff (rst)
                wr_ctrl |=> (div_req == $past(req.data[DIV_LSB +: DIV_W])));
        end
    endgenerate

endmodule

// File: rtl/halfdiv_srcpath.sv
module halfdiv_srcpath
    import halfdiv_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int SEL_W    = 2,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_clk,
    input  logic [SEL_W-1:0] sel_req,
    input  logic             gate_req,
    output logic             g_lvl,
    output logic             gate_on
);

    logic [NSRC-1:0]  src_q;
    logic [SEL_W-1:0] sel_act;
    logic             cur_lvl, req_lvl;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_clk;
    end

    // levels of the active and the requested source; absent sources read low
    always_comb begin
        cur_lvl = 1'b0;
        req_lvl = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (SEL_W'(k) == sel_act) cur_lvl = src_q[k];
            if (SEL_W'(k) == sel_req) req_lvl = src_q[k];
        end
    end

    generate
        if (NSRC > 1) begin : g_mux
            always_ff @(posedge clk) begin
                if (rst)
                    sel_act <= '0;
                else if (sel_req != sel_act && !cur_lvl && !req_lvl)
                    sel_act <= sel_req;
            end
        end else begin : g_single
            assign sel_act = '0;
        end

        if (HAS_GATE) begin : g_gate
            always_ff @(posedge clk) begin
                if (rst)
                    gate_on <= 1'b0;
                else if (gate_req != gate_on && !cur_lvl)
                    gate_on <= gate_req;
            end
        end else begin : g_nogate
            assign gate_on = gate_req;
        end
    endgenerate

    assign g_lvl = cur_lvl & gate_on;

    assert_gate_low_R5: assert property (@(posedge clk) disable iff (rst)
        (gate_on != $past(gate_on)) |-> !$past(cur_lvl));

    assert_sel_low_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_act != $past(sel_act)) |-> (!$past(cur_lvl) && !$past(req_lvl)));

endmodule

// File: rtl/halfdiv_core.sv
module halfdiv_core
    import halfdiv_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             g_lvl,
    input  logic             gate_on,
    input  logic [DIV_W-1:0] div_req,
    output logic             clk_out
);

    localparam int CNT_W = cnt_width(DIV_W);

    logic             g_prev;
    logic [CNT_W-1:0] cnt, wrap_pt, hi_lim;
    logic [DIV_W-1:0] n_act;
    logic             half_edge;

    assign half_edge = g_lvl ^ g_prev;
    assign wrap_pt   = CNT_W'({n_act, 1'b0}) + CNT_W'(2);
    assign hi_lim    = CNT_W'(n_act) + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            g_prev <= 1'b0;
            cnt    <= CNT_W'(2);
            n_act  <= '0;
        end else begin
            g_prev <= g_lvl;
            if (half_edge) begin
                if (cnt == wrap_pt) begin
                    cnt   <= '0;
                    n_act <= div_req;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign clk_out = gate_on && (cnt <= hi_lim);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= wrap_pt);

    assert_reload_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (n_act != $past(n_act)) |-> (cnt == '0));

endmodule

// File: rtl/halfdiv_clk_branch.sv
module halfdiv_clk_branch
    import halfdiv_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int SEL_LSB  = 0,
    parameter int DIV_W    = 4,
    parameter int DIV_LSB  = 8,
    parameter int GATE_BIT = 3,
    parameter bit MASKED   = 1'b1,
    parameter bit SEL_RO   = 1'b0,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_clk,
    input  logic            wr_en,
    input  logic            wr_tgt,
    input  logic [31:0]     wr_data,
    output logic            clk_out
);

    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    wr_req_t          req;
    logic [SEL_W-1:0] sel_req;
    logic [DIV_W-1:0] div_req;
    logic             gate_req, g_lvl, gate_on;

    assign req = '{en: wr_en, tgt: wr_tgt_e'(wr_tgt), data: wr_data};

    halfdiv_regs #(
        .SEL_W(SEL_W), .SEL_LSB(SEL_LSB), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB),
        .GATE_BIT(GATE_BIT), .MASKED(MASKED), .SEL_RO(SEL_RO), .HAS_GATE(HAS_GATE)
    ) u_regs (
        .clk(clk), .rst(rst), .req(req),
        .sel_req(sel_req), .div_req(div_req), .gate_req(gate_req)
    );

    halfdiv_srcpath #(
        .NSRC(NSRC), .SEL_W(SEL_W), .HAS_GATE(HAS_GATE)
    ) u_src (
        .clk(clk), .rst(rst), .src_clk(src_clk), .sel_req(sel_req),
        .gate_req(gate_req), .g_lvl(g_lvl), .gate_on(gate_on)
    );

    halfdiv_core #(
        .DIV_W(DIV_W)
    ) u_core (
        .clk(clk), .rst(rst), .g_lvl(g_lvl), .gate_on(gate_on),
        .div_req(div_req), .clk_out(clk_out)
    );

endmodule

// File: tb/halfdiv_clk_branch_bench.sv
module halfdiv_ref #(
    parameter bit MASKED = 1'b1,
    parameter bit SEL_RO = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  src,
    input  logic        wr_en,
    input  logic        wr_tgt,
    input  logic [31:0] wr_data,
    output logic        exp_out
);
    logic [3:0] samp, n_req;
    logic [1:0] sel_req;
    int sel_now, n_now, pos;
    bit gate_req, gate_now, prev_g, lvl, g;

    initial exp_out = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            samp = 0; n_req = 0; sel_req = 0; sel_now = 0; n_now = 0;
            pos = 0; gate_req = 0; gate_now = 0; prev_g = 0;
        end else begin
            lvl = samp[sel_now];
            g = lvl && gate_now;
            if (g != prev_g) begin
                if (pos == 0) begin n_now = int'(n_req); pos = 2 * n_now + 2; end
                else pos = pos - 1;
            end
            prev_g = g;
            if (!lvl) gate_now = gate_req;
            if (!samp[sel_now] && !samp[sel_req]) sel_now = int'(sel_req);
            if (wr_en) begin
                if (!wr_tgt) begin
                    for (int b = 0; b < 4; b++)
                        if (!MASKED || wr_data[24+b]) n_req[b] = wr_data[8+b];
                    if (!SEL_RO)
                        for (int b = 0; b < 2; b++)
                            if (!MASKED || wr_data[16+b]) sel_req[b] = wr_data[b];
                end else if (!MASKED || wr_data[19]) begin
                    gate_req = wr_data[3];
                end
            end
            samp = src;
        end
        exp_out = gate_now && (pos > n_now);
    end
endmodule

module halfdiv_clk_branch_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] src = 4'b0;
    logic wr_en = 1'b0, wr_tgt = 1'b0;
    logic [31:0] wr_data = '0;
    logic out_m, out_p, exp_m, exp_p;
    int checks = 0, errors = 0, cyc = 0;
    int ctr [4] = '{0, 0, 0, 0};
    int half [4] = '{2, 3, 5, 4};
    string phase = "R1 reset";

    always #10 clk = ~clk;

    halfdiv_clk_branch u_halfdiv_clk_branch (
        .clk(clk), .rst(rst), .src_clk(src), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_data(wr_data), .clk_out(out_m));

    halfdiv_clk_branch #(.MASKED(1'b0), .SEL_RO(1'b1)) u_plain (
        .clk(clk), .rst(rst), .src_clk(src), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_data(wr_data), .clk_out(out_p));

    halfdiv_ref #(.MASKED(1'b1), .SEL_RO(1'b0)) m_ref (
        .clk(clk), .rst(rst), .src(src), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_data(wr_data), .exp_out(exp_m));

    halfdiv_ref #(.MASKED(1'b0), .SEL_RO(1'b1)) p_ref (
        .clk(clk), .rst(rst), .src(src), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_data(wr_data), .exp_out(exp_p));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < 4; i++) begin
            ctr[i]++;
            if (ctr[i] == half[i]) begin ctr[i] = 0; src[i] = ~src[i]; end
        end
        chk(out_m === exp_m, {phase, " masked"}, int'(out_m), int'(exp_m));
        chk(out_p === exp_p, {phase, " plain"}, int'(out_p), int'(exp_p));
        if (cyc == 60000) begin
            chk(1'b0, "watchdog", cyc, 60000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic pick(input bit plain);
        return plain ? out_p : out_m;
    endfunction

    task automatic write_word(input bit tgt, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tgt = tgt; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_rise(input bit plain);
        logic prv, cur;
        cur = pick(plain);
        do begin
            prv = cur;
            @(negedge clk);
            cur = pick(plain);
        end while (!(!prv && cur));
    endtask

    task automatic measure(input bit plain, input int exp_hi, input int exp_lo, input string tag);
        int hi, lo;
        wait_rise(plain);
        wait_rise(plain);
        hi = 0;
        while (pick(plain)) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pick(plain)) begin lo++; @(negedge clk); end
        chk(hi == exp_hi, {tag, " high"}, hi, exp_hi);
        chk(lo == exp_lo, {tag, " low"}, lo, exp_lo);
    endtask

    task automatic count_high(input bit plain, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pick(plain)) hits++;
        end
    endtask

    initial begin
        int hits;
        repeat (5) @(negedge clk);
        chk(out_m == 1'b0, "R1 reset masked", int'(out_m), 0);
        chk(out_p == 1'b0, "R1 reset plain", int'(out_p), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_m == 1'b0, "R1 after reset", int'(out_m), 0);

        phase = "R3 minimum ratio";
        write_word(1'b1, 32'h0008_0008);
        measure(1'b0, 4, 2, "R3 N=0 masked");
        measure(1'b1, 4, 2, "R8 N=0 plain");

        phase = "R2 ratio";
        write_word(1'b0, 32'h0F00_0200);
        measure(1'b0, 8, 6, "R2 N=2 masked");
        measure(1'b1, 8, 6, "R2 N=2 plain");

        phase = "R3 maximum ratio";
        write_word(1'b0, 32'h0F00_0F00);
        measure(1'b0, 34, 32, "R3 N=15");

        phase = "R4 deferred reload";
        wait_rise(1'b0);
        repeat (3) @(negedge clk);
        write_word(1'b0, 32'h0F00_0100);
        repeat (5) @(negedge clk);
        chk(out_m == 1'b1, "R4 period kept whole", int'(out_m), 1);
        measure(1'b0, 6, 4, "R4 N=1 after reload");

        phase = "R6 source switch";
        write_word(1'b0, 32'h0003_0002);
        measure(1'b0, 15, 10, "R6 src2 N=1");
        measure(1'b1, 4, 2, "R9 fixed selector N=0");

        phase = "R7 unmasked bits";
        write_word(1'b0, 32'h0000_0700);
        measure(1'b0, 15, 10, "R7 write without enables");
        measure(1'b1, 18, 16, "R8 plain N=7");

        phase = "R7 partial mask";
        write_word(1'b0, 32'h0400_0600);
        measure(1'b0, 35, 30, "R7 one enabled bit");
        measure(1'b1, 16, 14, "R8 plain N=6");

        phase = "R6 second switch";
        write_word(1'b0, 32'h0003_0603);
        measure(1'b0, 28, 24, "R6 src3 N=5");

        phase = "R5 gate off";
        write_word(1'b1, 32'h0008_0000);
        repeat (20) @(negedge clk);
        count_high(1'b0, 40, hits);
        chk(hits == 0, "R5 gated masked", hits, 0);
        count_high(1'b1, 40, hits);
        chk(hits == 0, "R5 gated plain", hits, 0);

        phase = "R7 gate enable ignored";
        write_word(1'b1, 32'h0000_0008);
        count_high(1'b0, 80, hits);
        chk(hits == 0, "R7 gate bit without enable", hits, 0);
        count_high(1'b1, 80, hits);
        chk(hits > 0, "R8 plain gate on", hits, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule